// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers thirteen peripheral event requests and seven software interrupt requests and picks the one the processor should take next. Each event source has its own enable bit and a three-bit priority field, and a single global enable gates every event. A nonzero priority field p places the source at execution level 8+p, which gives levels 9 to 15. Software interrupt n (1 to 7) has a fixed level n, so it sits below every event and can only be taken once the processor has lowered its current level below n.

Every cycle the arbiter finds the highest-level pending source. Equal levels are settled by a fixed rank, with the lower rank winning. A request goes to the processor only when that level is strictly above the current processor priority. A three-state handshake machine has these states: `ST_IDLE` (arbitrating), `ST_REQ` (request raised, vector and level latched) and `ST_ACK` (acknowledge taken, outputs frozen). It has these transitions:
- `IDLE->REQ`: a winner beats the current level.
- `REQ->REQ`: the winner still beats the current level. The outputs are re-latched, so a higher-level arrival preempts a request that has not yet been taken.
- `REQ->IDLE`: the condition is withdrawn before an acknowledge.
- `REQ->ACK`: on acknowledge.
- `ACK->IDLE`: always, after one cycle.

Clearing a flag is left to the source that raised it.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset `irq_req` is 0, `irq_vec` and `irq_lvl` are 0, and all event enables, the global enable, all software enables and all priority fields are 0. As a result, no flag can raise a request until configuration is written.
- R2: A priority field of 0 removes its event source from arbitration. A value p from 1 to 7 gives that source level 8+p. No request ever carries level 0 or level 8.
- R3: An event competes only when three conditions hold: its flag is set, its enable bit `en_wdata[i]` is set, and the global enable `en_wdata[13]` is set. A software interrupt competes only when both its request bit and its enable bit are set. Bit i of `sw_req` and of `sw_en_wdata` is software interrupt i+1.
- R4: Among the competing sources, the one with the highest level wins.
- R5: Among competing sources of equal level, the lowest index in `evt_flag` wins. The index order is:

  | Index | Source |
  |---|---|
  | 0 | external 0 |
  | 1 | timer 0 |
  | 2 | external 1 |
  | 3 | timer 1 |
  | 4 | timer 2 |
  | 5 | CAN rx buffer full |
  | 6 | serial rx |
  | 7 | serial tx |
  | 8 | SPI |
  | 9 | CAN frame error |
  | 10 | CAN message error |
  | 11 | CAN tx done |
  | 12 | CAN rx done |

- R6: Event vectors are as follows:
  - Indices 0 to 5: 0x80+4*index.
  - Index 6: 0xA0.
  - Index 7: 0xA4.
  - Index 8: 0xAC.
  - Indices 9 to 12: 0xB0+4*(index-9).
- R7: The timer 2 request (index 4) is the OR of `evt_flag[4]` and `t2_cap_flag`.
- R8: Software interrupt n runs at level n, with vector 0x100+4*(n-1).
- R9: A request is raised only when the winning level is strictly greater than `cur_lvl`. The outputs appear the cycle after the inputs that cause them.
- R10: While `irq_req` is high and `irq_ack` is low, a new winner that still beats `cur_lvl` replaces the latched vector and level on the next cycle. An acknowledge has two effects on the next cycle: `irq_req` drops, and the vector and level hold unchanged. Arbitration resumes one cycle after that.
- R11: If no competing source beats `cur_lvl` while `irq_req` is high and unacknowledged, `irq_req` drops on the next cycle.
- R12: A priority write with `prio_idx` of 13 or more changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_flag | input | 13 | Event request flags, index = rank |
| t2_cap_flag | input | 1 | Timer 2 capture flag, ORed into index 4 |
| sw_req | input | 7 | Software interrupt request bits |
| en_we | input | 1 | Write strobe for event and global enables |
| en_wdata | input | 14 | Bits 12:0 are event enables, bit 13 is the global enable |
| sw_en_we | input | 1 | Write strobe for software enables |
| sw_en_wdata | input | 7 | Software enable bits |
| prio_we | input | 1 | Write strobe for one priority field |
| prio_idx | input | 4 | Event index of the priority field |
| prio_wdata | input | 3 | Priority value, 0 disables |
| cur_lvl | input | 4 | Current processor priority level |
| irq_ack | input | 1 | Processor takes the pending request |
| irq_req | output | 1 | Request to the processor |
| irq_vec | output | 12 | Vector address of the latched winner |
| irq_lvl | output | 4 | Execution level of the latched winner |

## Verification
The hardest situation to reach is a change of winner while a request is raised but not yet acknowledged. This case covers both preemption by a higher level and withdrawal once `cur_lvl` catches up. Random stimulus always acknowledges, so it never gets there. A directed sequence therefore holds off the acknowledge, adds a higher-level flag one cycle later, and then lifts `cur_lvl` above it. Random trials over enables, priority fields, flags, software bits and current level cover ties and the software band. A bench function predicts each winner from the written configuration.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int NUM_EVT  = 13;
    localparam int NUM_SW   = 7;
    localparam int NUM_SRC  = NUM_EVT + NUM_SW;
    localparam int PRIO_W   = 3;
    localparam int LVL_W    = 4;
    localparam int VEC_W    = 12;
    localparam int IDX_W    = $clog2(NUM_SRC);
    localparam int EIDX_W   = $clog2(NUM_EVT + 1);
    localparam int T2_IDX   = 4;
    localparam int EVT_BASE = 8;
    localparam logic [VEC_W-1:0] SW_VEC_BASE = 12'h100;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_ACK  = 2'd2
    } irq_state_t;

    // Vector of event slot i; the holes in the map are kept.
    function automatic logic [VEC_W-1:0] evt_vector(input int i);
        logic [VEC_W-1:0] v;
        if (i < 6)       v = VEC_W'(12'h080 + 4 * i);
        else if (i < 8)  v = VEC_W'(12'h0A0 + 4 * (i - 6));
        else if (i == 8) v = 12'h0AC;
        else             v = VEC_W'(12'h0B0 + 4 * (i - 9));
        return v;
    endfunction

    function automatic logic [VEC_W-1:0] src_vector(input logic [IDX_W-1:0] idx);
        int i;
        i = int'(idx);
        if (i < NUM_EVT) return evt_vector(i);
        return VEC_W'(SW_VEC_BASE + VEC_W'(4 * (i - NUM_EVT)));
    endfunction
endpackage

// File: rtl/irqc_cfg_regs.sv
module irqc_cfg_regs
    import irqc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_we,
    input  logic [NUM_EVT:0]     en_wdata,
    input  logic                 sw_en_we,
    input  logic [NUM_SW-1:0]    sw_en_wdata,
    input  logic                 prio_we,
    input  logic [EIDX_W-1:0]    prio_idx,
    input  logic [PRIO_W-1:0]    prio_wdata,
    output logic [NUM_EVT-1:0]   evt_en,
    output logic                 glb_en,
    output logic [NUM_SW-1:0]    sw_en,
    output logic [PRIO_W-1:0]    prio [NUM_EVT]
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            evt_en <= '0;
            glb_en <= 1'b0;
        end else if (en_we) begin
            evt_en <= en_wdata[NUM_EVT-1:0];
            glb_en <= en_wdata[NUM_EVT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)        sw_en <= '0;
        else if (sw_en_we) sw_en <= sw_en_wdata;
    end

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_prio
        always_ff @(posedge clk) begin
            if (!rst_n)
                prio[g] <= '0;
            else if (prio_we && (prio_idx == EIDX_W'(g)))
                prio[g] <= prio_wdata;
        end
    end
endmodule

// File: rtl/irqc_src_gate.sv
module irqc_src_gate
    import irqc_pkg::*;
(
    input  logic [NUM_EVT-1:0]  evt_flag,
    input  logic                t2_cap_flag,
    input  logic [NUM_SW-1:0]   sw_req,
    input  logic [NUM_EVT-1:0]  evt_en,
    input  logic                glb_en,
    input  logic [NUM_SW-1:0]   sw_en,
    input  logic [PRIO_W-1:0]   prio [NUM_EVT],
    output logic [LVL_W-1:0]    src_lvl [NUM_SRC]
);
    // Level 0 marks a source that does not compete.
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        logic raw;
        if (g == T2_IDX) begin : g_t2
            assign raw = evt_flag[g] | t2_cap_flag;
        end else begin : g_plain
            assign raw = evt_flag[g];
        end
        assign src_lvl[g] = (raw && evt_en[g] && glb_en && (prio[g] != '0))
                          ? LVL_W'(EVT_BASE + int'(prio[g])) : '0;
    end

    for (genvar s = 0; s < NUM_SW; s++) begin : g_sw
        assign src_lvl[NUM_EVT + s] = (sw_req[s] && sw_en[s]) ? LVL_W'(s + 1) : '0;
    end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
    import irqc_pkg::*;
(
    input  logic [LVL_W-1:0]  src_lvl [NUM_SRC],
    output logic              win_valid,
    output logic [LVL_W-1:0]  win_lvl,
    output logic [VEC_W-1:0]  win_vec
);
    logic [IDX_W-1:0] best_idx;
    logic [LVL_W-1:0] best_lvl;

    // Scan in rank order; strict compare keeps the lower rank on a tie.
    always_comb begin
        best_lvl = '0;
        best_idx = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (src_lvl[i] > best_lvl) begin
                best_lvl = src_lvl[i];
                best_idx = IDX_W'(i);
            end
        end
    end

    assign win_valid = (best_lvl != '0);
    assign win_lvl   = best_lvl;
    assign win_vec   = src_vector(best_idx);
endmodule

// File: rtl/irqc_fsm.sv
module irqc_fsm
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_valid,
    input  logic [LVL_W-1:0]  win_lvl,
    input  logic [VEC_W-1:0]  win_vec,
    input  logic [LVL_W-1:0]  cur_lvl,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic [LVL_W-1:0]  irq_lvl
);
    irq_state_t state, state_nx;
    logic       beats;
    logic       load;

    assign beats = win_valid && (win_lvl > cur_lvl);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (beats) begin
                    state_nx = ST_REQ;
                    load     = 1'b1;
                end
            end
            ST_REQ: begin
                if (irq_ack) begin
                    state_nx = ST_ACK;
                end else if (beats) begin
                    load = 1'b1;
                end else begin
                    state_nx = ST_IDLE;
                end
            end
            ST_ACK: begin
                state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_vec <= '0;
            irq_lvl <= '0;
        end else if (load) begin
            irq_vec <= win_vec;
            irq_lvl <= win_lvl;
        end
    end

    assign irq_req = (state == ST_REQ);
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irqc_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EVT-1:0]  evt_flag,
    input  logic                t2_cap_flag,
    input  logic [NUM_SW-1:0]   sw_req,
    input  logic                en_we,
    input  logic [NUM_EVT:0]    en_wdata,
    input  logic                sw_en_we,
    input  logic [NUM_SW-1:0]   sw_en_wdata,
    input  logic                prio_we,
    input  logic [EIDX_W-1:0]   prio_idx,
    input  logic [PRIO_W-1:0]   prio_wdata,
    input  logic [LVL_W-1:0]    cur_lvl,
    input  logic                irq_ack,
    output logic                irq_req,
    output logic [VEC_W-1:0]    irq_vec,
    output logic [LVL_W-1:0]    irq_lvl
);
    logic [NUM_EVT-1:0] evt_en;
    logic               glb_en;
    logic [NUM_SW-1:0]  sw_en;
    logic [PRIO_W-1:0]  prio [NUM_EVT];
    logic [LVL_W-1:0]   src_lvl [NUM_SRC];
    logic               win_valid;
    logic [LVL_W-1:0]   win_lvl;
    logic [VEC_W-1:0]   win_vec;

    irqc_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n),
        .en_we(en_we), .en_wdata(en_wdata),
        .sw_en_we(sw_en_we), .sw_en_wdata(sw_en_wdata),
        .prio_we(prio_we), .prio_idx(prio_idx), .prio_wdata(prio_wdata),
        .evt_en(evt_en), .glb_en(glb_en), .sw_en(sw_en), .prio(prio)
    );

    irqc_src_gate u_gate (
        .evt_flag(evt_flag), .t2_cap_flag(t2_cap_flag), .sw_req(sw_req),
        .evt_en(evt_en), .glb_en(glb_en), .sw_en(sw_en), .prio(prio),
        .src_lvl(src_lvl)
    );

    irqc_arbiter u_arb (
        .src_lvl(src_lvl), .win_valid(win_valid),
        .win_lvl(win_lvl), .win_vec(win_vec)
    );

    irqc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .win_valid(win_valid), .win_lvl(win_lvl), .win_vec(win_vec),
        .cur_lvl(cur_lvl), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
    );
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
    import irqc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  cur_lvl,
    input logic              irq_ack,
    input logic              irq_req,
    input logic [VEC_W-1:0]  irq_vec,
    input logic [LVL_W-1:0]  irq_lvl
);
    AST_RISE_ABOVE_CUR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> (irq_lvl > $past(cur_lvl))); // R9

    AST_ACK_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> !irq_req); // R10

    AST_ACK_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_ack) |=> ($stable(irq_vec) && $stable(irq_lvl))); // R10

    AST_NO_DEAD_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> ((irq_lvl != 4'd0) && (irq_lvl != 4'd8))); // R2

    AST_SW_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && (irq_lvl < 4'd8)) |->
        (irq_vec == (12'h100 + {6'd0, irq_lvl - 4'd1, 2'b00}))); // R8

    AST_EVT_VECTOR_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && (irq_lvl > 4'd8)) |->
        ((irq_vec >= 12'h080) && (irq_vec <= 12'h0BC) && (irq_vec[1:0] == 2'b00))); // R6
endmodule

bind irq_vec_ctrl irqc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .irq_ack(irq_ack),
    .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
);

// File: tb/irq_vec_ctrl_test.sv
module irq_vec_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [12:0] evt_flag;
    logic        t2_cap_flag;
    logic [6:0]  sw_req;
    logic        en_we;
    logic [13:0] en_wdata;
    logic        sw_en_we;
    logic [6:0]  sw_en_wdata;
    logic        prio_we;
    logic [3:0]  prio_idx;
    logic [2:0]  prio_wdata;
    logic [3:0]  cur_lvl;
    logic        irq_ack;
    logic        irq_req;
    logic [11:0] irq_vec;
    logic [3:0]  irq_lvl;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    // Bench copy of the written configuration
    logic [12:0] m_en;
    logic        m_glb;
    logic [6:0]  m_sw;
    logic [2:0]  m_prio [13];

    always #5 clk = ~clk;

    irq_vec_ctrl uut (
        .clk(clk), .rst_n(rst_n), .evt_flag(evt_flag), .t2_cap_flag(t2_cap_flag),
        .sw_req(sw_req), .en_we(en_we), .en_wdata(en_wdata),
        .sw_en_we(sw_en_we), .sw_en_wdata(sw_en_wdata),
        .prio_we(prio_we), .prio_idx(prio_idx), .prio_wdata(prio_wdata),
        .cur_lvl(cur_lvl), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] ev_vec(input int i);
        case (i)
            0: return 12'h080;   1: return 12'h084;   2: return 12'h088;
            3: return 12'h08C;   4: return 12'h090;   5: return 12'h094;
            6: return 12'h0A0;   7: return 12'h0A4;   8: return 12'h0AC;
            9: return 12'h0B0;  10: return 12'h0B4;  11: return 12'h0B8;
            default: return 12'h0BC;
        endcase
    endfunction

    // Expected winner from requirements R2..R9
    task automatic predict(input logic [12:0] fl, input logic cap, input logic [6:0] sw,
                           input logic [3:0] cur, output bit v,
                           output logic [11:0] ev, output logic [3:0] el);
        int best;
        best = 0; ev = 12'h0; el = 4'h0;
        for (int i = 0; i < 13; i++) begin
            bit f;
            f = fl[i] | ((i == 4) ? cap : 1'b0);
            if (f && m_en[i] && m_glb && m_prio[i] != 0 && (8 + m_prio[i]) > best) begin
                best = 8 + m_prio[i]; ev = ev_vec(i); el = 4'(best);
            end
        end
        for (int n = 7; n >= 1; n--) begin
            if (best == 0 && sw[n-1] && m_sw[n-1]) begin
                best = n; ev = 12'(12'h100 + 4 * (n - 1)); el = 4'(n);
            end
        end
        v = (best != 0) && (best > int'(cur));
    endtask

    task automatic wr_en(input logic [13:0] d);
        @(negedge clk); en_we = 1; en_wdata = d;
        @(negedge clk); en_we = 0;
        m_en = d[12:0]; m_glb = d[13];
    endtask

    task automatic wr_sw(input logic [6:0] d);
        @(negedge clk); sw_en_we = 1; sw_en_wdata = d;
        @(negedge clk); sw_en_we = 0;
        m_sw = d;
    endtask

    task automatic wr_prio(input int idx, input logic [2:0] p);
        @(negedge clk); prio_we = 1; prio_idx = 4'(idx); prio_wdata = p;
        @(negedge clk); prio_we = 0;
        if (idx < 13) m_prio[idx] = p;
    endtask

    // One arbitration: drive, check the request, acknowledge, check the hold.
    task automatic trial(input logic [12:0] fl, input logic cap, input logic [6:0] sw,
                         input logic [3:0] cur, input string tag);
        bit v; logic [11:0] ev; logic [3:0] el;
        @(negedge clk);
        evt_flag = fl; t2_cap_flag = cap; sw_req = sw; cur_lvl = cur;
        predict(fl, cap, sw, cur, v, ev, el);
        @(negedge clk);
        chk(irq_req == v, {tag, " R9 req"}, irq_req, v);
        if (v) begin
            chk(irq_vec == ev, {tag, " vec"}, irq_vec, ev);
            chk(irq_lvl == el, {tag, " lvl"}, irq_lvl, el);
            irq_ack = 1;
            @(negedge clk);
            irq_ack = 0;
            chk(irq_req == 0, "R10 ack drop", irq_req, 0);
            chk(irq_vec == ev && irq_lvl == el, "R10 ack hold", irq_vec, ev);
        end
        evt_flag = '0; t2_cap_flag = 0; sw_req = '0; cur_lvl = '0;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        rst_n = 0; evt_flag = '0; t2_cap_flag = 0; sw_req = '0;
        en_we = 0; en_wdata = '0; sw_en_we = 0; sw_en_wdata = '0;
        prio_we = 0; prio_idx = '0; prio_wdata = '0; cur_lvl = '0; irq_ack = 0;
        m_en = '0; m_glb = 0; m_sw = '0;
        for (int i = 0; i < 13; i++) m_prio[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state, and nothing requests with cleared configuration
        chk(irq_req == 0, "R1 req", irq_req, 0);
        chk(irq_vec == 0, "R1 vec", irq_vec, 0);
        chk(irq_lvl == 0, "R1 lvl", irq_lvl, 0);
        trial(13'h1FFF, 1, 7'h7F, 0, "R1 unconfigured");

        // R2: priority 0 disables, p maps to 8+p
        wr_en(14'h3FFF);
        trial(13'h0001, 0, 0, 0, "R2 prio zero");
        wr_prio(0, 3'd1);
        trial(13'h0001, 0, 0, 0, "R2 level nine");
        // R12: out-of-range index writes nothing
        wr_prio(13, 3'd7);
        wr_prio(15, 3'd7);
        trial(13'h0001, 0, 0, 0, "R12 bad index");
        // R3: global enable and per-source enable gate events
        wr_en(14'h1FFF);
        trial(13'h0001, 0, 0, 0, "R3 global off");
        wr_en(14'h3FFE);
        trial(13'h0001, 0, 0, 0, "R3 source off");
        wr_en(14'h3FFF);
        // R6: every event vector at level 12
        for (int i = 0; i < 13; i++) wr_prio(i, 3'd4);
        for (int i = 0; i < 13; i++) trial(13'(1 << i), 0, 0, 0, "R6 vector");
        // R5: equal levels, lowest index wins
        trial(13'h0084, 0, 0, 0, "R5 tie");
        trial(13'h1E00, 0, 0, 0, "R5 tie CAN");
        // R4: highest level wins regardless of index
        wr_prio(12, 3'd7);
        wr_prio(0, 3'd6);
        trial(13'h1001, 0, 0, 0, "R4 highest");
        // R7: timer 2 capture alone requests at slot 4
        trial(13'h0000, 1, 0, 0, "R7 capture");
        // R8: software band and R9 strict compare
        wr_sw(7'h7F);
        trial(0, 0, 7'h40, 4'd6, "R8 sw7");
        trial(0, 0, 7'h40, 4'd7, "R9 equal level");
        trial(0, 0, 7'h05, 4'd0, "R8 sw3 over sw1");
        trial(13'h0002, 0, 7'h7F, 4'd0, "R8 event over sw");

        // R10 preemption before acknowledge, then R11 withdrawal
        wr_prio(1, 3'd2);
        wr_prio(9, 3'd5);
        @(negedge clk);
        evt_flag = 13'h0002; cur_lvl = 0;
        @(negedge clk);
        chk(irq_req && irq_vec == 12'h084, "R10 first winner", irq_vec, 12'h084);
        evt_flag = 13'h0202;
        @(negedge clk);
        chk(irq_req && irq_vec == 12'h0B0, "R10 preempt vec", irq_vec, 12'h0B0);
        chk(irq_lvl == 4'd13, "R10 preempt lvl", irq_lvl, 13);
        cur_lvl = 4'd15;
        @(negedge clk);
        chk(irq_req == 0, "R11 withdraw", irq_req, 0);
        evt_flag = '0; cur_lvl = 0;
        repeat (2) @(negedge clk);

        // Random mix, checked against the bench prediction
        for (int t = 0; t < 300; t++) begin
            logic [12:0] fl; logic [6:0] sw; logic [3:0] cur;
            if ($urandom_range(0, 3) == 0)
                wr_en({($urandom_range(0, 3) != 0), 13'($urandom)});
            if ($urandom_range(0, 1) == 0)
                wr_prio($urandom_range(0, 12), 3'($urandom));
            if ($urandom_range(0, 7) == 0)
                wr_sw(7'($urandom));
            fl  = 13'($urandom) & 13'($urandom);
            sw  = 7'($urandom);
            cur = ($urandom_range(0, 1) == 0) ? 4'd0 : 4'($urandom);
            trial(fl, 1'($urandom), sw, cur, "R4 R5 R6 R8 random");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule